// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block holds the control-flow divergence state of one wavefront of SIMD lanes. It keeps a bounded stack. Each entry stores three things: a program counter, the program counter at which the divergent paths rejoin, and a per-lane execution mask. The outputs are always read from the top entry. The lane predicate seen by the execution units is the top mask ANDed with a mask captured when the wavefront is started.

The front end pushes a new entry whenever a branch splits the lanes. It writes the next PC into the top entry as the wavefront advances. On every step strobe, the block compares the top PC with the top reconvergence PC, and on a match it drops the top entry. Branch evaluation, fetch and post-dominator analysis happen outside the block; their results arrive on the push and PC-update inputs. A start command clears the stack, loads the first entry and sets the wavefront running. Overflow and underflow are recorded in sticky flags.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, depth_o is 0, status_o is 0 (stopped), pc_o, rpc_o, mask_o and pred_o are 0, and both flags are 0.
- R2: A start loads one entry with PC start_pc_i, reconvergence PC all ones and mask init_mask_i. It also latches init_mask_i, clears both flags and sets status_o to 2 (running). The result is visible after the edge, and start takes priority over every other input.
- R3: pc_o, rpc_o and mask_o are the fields of the top entry, and pred_o is mask_o ANDed with the mask latched at start.
- R4: While running, push_i adds an entry {push_pc_i, push_rpc_i, push_mask_i} above the top, so it becomes the new top and depth_o rises by one.
- R5: A PC update (pc_wr_i) rewrites the PC of the top entry only, and every lower entry keeps its PC.
- R6: reconv_o is high combinationally when the stack is non-empty and the top PC equals the top reconvergence PC. A step strobe while running with reconv_o high and depth at least 2 removes the top entry at the next edge.
- R7: In one cycle the actions apply in this order: first the pop, then the PC update to the resulting top entry, then the push above it.
- R8: A push when the stack holds DEPTH entries (after any same-cycle pop) is ignored and sets the sticky overflow_o flag.
- R9: A step with reconv_o high at depth 1 leaves the entry in place and sets the sticky underflow_o flag.
- R10: ret_i moves status from running to 1 (returning), and stop_i moves any state to 0 (stopped). Outside the running state, step, push and PC update have no effect on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start the wavefront |
| start_pc_i | input | PCW | First PC of the wavefront |
| init_mask_i | input | LANES | Lanes enabled at start |
| step_i | input | 1 | Evaluate the pop condition this cycle |
| pc_wr_i | input | 1 | Write a new PC into the top entry |
| pc_wr_val_i | input | PCW | New PC value |
| push_i | input | 1 | Push a divergence entry |
| push_pc_i | input | PCW | PC of the pushed entry |
| push_rpc_i | input | PCW | Reconvergence PC of the pushed entry |
| push_mask_i | input | LANES | Lane mask of the pushed entry |
| ret_i | input | 1 | Running to returning |
| stop_i | input | 1 | Any state to stopped |
| pc_o | output | PCW | Top entry PC |
| rpc_o | output | PCW | Top entry reconvergence PC |
| mask_o | output | LANES | Top entry lane mask |
| pred_o | output | LANES | Effective lane predicate |
| reconv_o | output | 1 | Top PC equals top reconvergence PC |
| depth_o | output | $clog2(DEPTH+1) | Number of stacked entries |
| status_o | output | 2 | 0 stopped, 1 returning, 2 running |
| overflow_o | output | 1 | Sticky push-when-full flag |
| underflow_o | output | 1 | Sticky pop-at-last-entry flag |

## Verification
Directed sequences cover specific corner cases. Nested pushes followed by PC writes and pops show whether writes stay in the top entry and whether lower entries survive. Filling to DEPTH and pushing again tells a dropped push apart from one that wraps or corrupts. A same-cycle pop, PC update and push, and a match at depth 1, tell the ordering rule apart from other orderings and separate the underflow case from a normal pop. Random runs use a small pool of PC values so that matches happen often. They mix all the commands, including return, stop and restart, so the bench can show whether commands are ignored outside the running state.

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int LANES = 16,
  parameter int PCW   = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [PCW-1:0]               start_pc_i,
  input  logic [LANES-1:0]             init_mask_i,
  input  logic                         step_i,
  input  logic                         pc_wr_i,
  input  logic [PCW-1:0]               pc_wr_val_i,
  input  logic                         push_i,
  input  logic [PCW-1:0]               push_pc_i,
  input  logic [PCW-1:0]               push_rpc_i,
  input  logic [LANES-1:0]             push_mask_i,
  input  logic                         ret_i,
  input  logic                         stop_i,
  output logic [PCW-1:0]               pc_o,
  output logic [PCW-1:0]               rpc_o,
  output logic [LANES-1:0]             mask_o,
  output logic [LANES-1:0]             pred_o,
  output logic                         reconv_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o,
  output logic [1:0]                   status_o,
  output logic                         overflow_o,
  output logic                         underflow_o
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DW-1:0] FULL = DW'(DEPTH);
  localparam logic [1:0] ST_STOP = 2'd0, ST_RET = 2'd1, ST_RUN = 2'd2;

  logic [PCW-1:0]   pc_q   [DEPTH];
  logic [PCW-1:0]   rpc_q  [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];
  logic [LANES-1:0] init_q;
  logic [DW-1:0]    depth_q;
  logic [1:0]       status_q;
  logic             ovf_q, unf_q;

  wire            running  = (status_q == ST_RUN);
  wire            nonempty = (depth_q != '0);
  wire [IW-1:0]   top      = IW'(depth_q - 1'b1);

  assign pc_o     = nonempty ? pc_q[top]   : '0;
  assign rpc_o    = nonempty ? rpc_q[top]  : '0;
  assign mask_o   = nonempty ? mask_q[top] : '0;
  assign pred_o   = mask_o & init_q;
  assign reconv_o = nonempty && (pc_o == rpc_o);

  wire            hit      = running && step_i && reconv_o;
  wire            do_pop   = hit && (depth_q > DW'(1));
  wire            do_unf   = hit && (depth_q <= DW'(1));
  wire [DW-1:0]   base     = do_pop ? depth_q - 1'b1 : depth_q;
  wire [IW-1:0]   base_top = IW'(base - 1'b1);
  wire [IW-1:0]   push_idx = IW'(base);
  wire            do_pcwr  = running && pc_wr_i && (base != '0);
  wire            do_push  = running && push_i && (base < FULL);
  wire            do_ovf   = running && push_i && (base >= FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        pc_q[i]   <= '0;
        rpc_q[i]  <= '0;
        mask_q[i] <= '0;
      end
      init_q   <= '0;
      depth_q  <= '0;
      status_q <= ST_STOP;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else if (start_i) begin
      pc_q[0]   <= start_pc_i;
      rpc_q[0]  <= '1;
      mask_q[0] <= init_mask_i;
      init_q    <= init_mask_i;
      depth_q   <= DW'(1);
      status_q  <= ST_RUN;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      if (do_pcwr) pc_q[base_top] <= pc_wr_val_i;
      if (do_push) begin
        pc_q[push_idx]   <= push_pc_i;
        rpc_q[push_idx]  <= push_rpc_i;
        mask_q[push_idx] <= push_mask_i;
      end
      depth_q <= base + DW'(do_push);
      ovf_q   <= ovf_q | do_ovf;
      unf_q   <= unf_q | do_unf;
      if (stop_i)              status_q <= ST_STOP;
      else if (ret_i && running) status_q <= ST_RET;
    end
  end

  assign depth_o     = depth_q;
  assign status_o    = status_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= FULL);

  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (depth_o == DW'(1)) && (rpc_o == '1) && (status_o == ST_RUN)
                && !overflow_o && !underflow_o);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !start_i) |=> overflow_o);

  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && !start_i) |=> underflow_o);

  a_r8_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && status_o == ST_RUN && push_i && depth_o == FULL && !step_i)
      |=> overflow_o && (depth_o == FULL));

  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && status_o == ST_RUN && step_i && reconv_o && !push_i
     && depth_o > DW'(1)) |=> (depth_o == $past(depth_o) - 1'b1));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && status_o != ST_RUN) |=> $stable(depth_o) && $stable(pc_o));
endmodule

// File: tb/tb_simt_reconv_stack.sv
`timescale 1ns/1ps
module tb_simt_reconv_stack;
  localparam int LANES = 16, PCW = 32, DEPTH = 8;
  localparam int DW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic start_i = 0, step_i = 0, pc_wr_i = 0, push_i = 0, ret_i = 0, stop_i = 0;
  logic [PCW-1:0] start_pc_i = 0, pc_wr_val_i = 0, push_pc_i = 0, push_rpc_i = 0;
  logic [LANES-1:0] init_mask_i = 0, push_mask_i = 0;
  logic [PCW-1:0] pc_o, rpc_o;
  logic [LANES-1:0] mask_o, pred_o;
  logic reconv_o, overflow_o, underflow_o;
  logic [DW-1:0] depth_o;
  logic [1:0] status_o;

  simt_reconv_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) dut (.*);

  always #2 clk = ~clk;

  int vectors = 0, errors = 0;

  // reference model
  logic [PCW-1:0]   m_pc [DEPTH];
  logic [PCW-1:0]   m_rpc [DEPTH];
  logic [LANES-1:0] m_mask [DEPTH];
  logic [LANES-1:0] m_init = 0;
  int m_depth = 0;
  logic [1:0] m_st = 0;
  logic m_ovf = 0, m_unf = 0;

  function automatic logic [PCW-1:0] e_pc();
    return m_depth > 0 ? m_pc[m_depth-1] : '0;
  endfunction
  function automatic logic [PCW-1:0] e_rpc();
    return m_depth > 0 ? m_rpc[m_depth-1] : '0;
  endfunction
  function automatic logic [LANES-1:0] e_mask();
    return m_depth > 0 ? m_mask[m_depth-1] : '0;
  endfunction

  task automatic model_step();
    int b;
    logic run;
    if (start_i) begin
      m_depth = 1; m_pc[0] = start_pc_i; m_rpc[0] = '1; m_mask[0] = init_mask_i;
      m_init = init_mask_i; m_st = 2; m_ovf = 0; m_unf = 0;
      return;
    end
    run = (m_st == 2);
    b = m_depth;
    if (run && step_i && m_depth > 0 && e_pc() == e_rpc()) begin
      if (m_depth >= 2) b = m_depth - 1; else m_unf = 1;
    end
    if (run && pc_wr_i && b > 0) m_pc[b-1] = pc_wr_val_i;
    if (run && push_i) begin
      if (b < DEPTH) begin
        m_pc[b] = push_pc_i; m_rpc[b] = push_rpc_i; m_mask[b] = push_mask_i; b++;
      end else m_ovf = 1;
    end
    m_depth = b;
    if (stop_i) m_st = 0;
    else if (ret_i && run) m_st = 1;
  endtask

  task automatic check(input string tag);
    logic [PCW-1:0] ep, er;
    logic [LANES-1:0] em;
    logic erc;
    ep = e_pc(); er = e_rpc(); em = e_mask();
    erc = (m_depth > 0) && (ep == er);
    vectors++;
    if (pc_o !== ep || rpc_o !== er || mask_o !== em || pred_o !== (em & m_init) ||
        reconv_o !== erc || depth_o !== DW'(m_depth) || status_o !== m_st ||
        overflow_o !== m_ovf || underflow_o !== m_unf) begin
      errors++;
      $display("FAIL %s: got pc=%h rpc=%h mask=%h pred=%h rc=%b d=%0d st=%0d o=%b u=%b exp pc=%h rpc=%h mask=%h pred=%h rc=%b d=%0d st=%0d o=%b u=%b",
        tag, pc_o, rpc_o, mask_o, pred_o, reconv_o, depth_o, status_o, overflow_o, underflow_o,
        ep, er, em, em & m_init, erc, m_depth, m_st, m_ovf, m_unf);
    end
  endtask

  task automatic idle_inputs();
    start_i = 0; step_i = 0; pc_wr_i = 0; push_i = 0; ret_i = 0; stop_i = 0;
  endtask

  // inputs already set by caller at negedge; advance one edge and compare
  task automatic tick(input string tag);
    model_step();
    @(posedge clk); #1;
    check(tag);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_start(input logic [PCW-1:0] p, input logic [LANES-1:0] m, input string tag);
    start_i = 1; start_pc_i = p; init_mask_i = m; tick(tag);
  endtask
  task automatic do_push(input logic [PCW-1:0] p, r, input logic [LANES-1:0] m, input string tag);
    push_i = 1; push_pc_i = p; push_rpc_i = r; push_mask_i = m; tick(tag);
  endtask
  task automatic do_pcwr(input logic [PCW-1:0] p, input string tag);
    pc_wr_i = 1; pc_wr_val_i = p; tick(tag);
  endtask
  task automatic do_step(input string tag);
    step_i = 1; tick(tag);
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    $display("FAIL watchdog: got hung run, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk); #1; check("R1 reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk); check("R1 after release");

    do_start(32'h10, 16'h0FFF, "R2 start");
    do_push(32'h20, 32'h30, 16'h00F0, "R4 push");
    do_push(32'h40, 32'h50, 16'hF00F, "R3 pred of top");
    do_pcwr(32'h50, "R5 top pc write");
    step_i = 1; tick("R6 pop on match");
    do_pcwr(32'h30, "R5 write second level");
    do_step("R6 pop to base; base pc intact R5");
    do_step("R9 no match at depth1");
    do_pcwr(32'hFFFF_FFFF, "R5 base pc to ones");
    do_step("R9 underflow at depth1");
    do_pcwr(32'h14, "R9 entry kept");
    for (int i = 0; i < DEPTH - 1; i++) do_push(32'h100 + i*4, 32'h200, 16'h1 << i, "R4 fill");
    do_push(32'h300, 32'h304, 16'hAAAA, "R8 push when full ignored");
    do_push(32'h308, 32'h30C, 16'h5555, "R8 sticky");
    do_pcwr(32'h200, "R5 top to rpc");
    step_i = 1; pc_wr_i = 1; pc_wr_val_i = 32'h77; push_i = 1;
    push_pc_i = 32'h88; push_rpc_i = 32'h99; push_mask_i = 16'h0F0F;
    tick("R7 pop then write then push");
    do_step("R7 new top no match");
    ret_i = 1; tick("R10 to returning");
    do_push(32'h1, 32'h1, 16'hFFFF, "R10 push ignored when returning");
    do_pcwr(32'h2, "R10 pcwr ignored when returning");
    stop_i = 1; tick("R10 stop");
    start_i = 1; start_pc_i = 32'h8; init_mask_i = 16'hFFFF; stop_i = 1; push_i = 1;
    tick("R2 start priority");

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 100;
      if (r < 2) begin
        start_i = 1; start_pc_i = ($urandom % 8) * 4; init_mask_i = LANES'($urandom);
      end else if (r < 3) ret_i = 1;
      else if (r < 4) stop_i = 1;
      else begin
        step_i = ($urandom % 2) == 1;
        pc_wr_i = ($urandom % 3) == 0;
        pc_wr_val_i = ($urandom % 8) * 4;
        push_i = ($urandom % 4) == 0;
        push_pc_i = ($urandom % 8) * 4;
        push_rpc_i = ($urandom % 8) * 4;
        push_mask_i = LANES'($urandom);
      end
      if (m_st != 2 && ($urandom % 10) == 0) begin
        start_i = 1; start_pc_i = 32'h4; init_mask_i = LANES'($urandom);
      end
      tick("R3/R4/R6/R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule